// File: doc/BRIEF.md
# Leading-One Position Detector

This block looks at an input vector and reports where its most significant set bit sits. The result is one-based: the lowest bit reports 1, the top bit reports the vector width, and an empty vector reports 0. No valid flag is needed, because the zero code already means "no bit set". The logic is purely combinational. The result follows the input within the same cycle and holds no state.

A string parameter picks one of four internal structures. `PRIORITY` is a two-level grouped priority encoder. `SCAN_DOWN` is a loop that walks from the top bit and keeps the first hit. `SCAN_UP` is a loop that walks from the bottom bit and lets the last hit win. `ONEHOT` is an OR-encoder that assumes at most one bit is set. It is the cheapest form, but it is only defined for one-hot or empty inputs. Any other style string stops elaboration with an error.

The output is `$clog2(WIDTH+1)` bits wide, which is 5 bits for the 16-bit default. The loop bounds come from the declared range of the input, so every style scales with `WIDTH`.

Top module: `lead_one_det`

## Requirements
- R1: For styles `PRIORITY`, `SCAN_DOWN` and `SCAN_UP`, and any input, `pos_o` equals the index of the highest set bit of `vec_i` plus one.
- R2: For every style, an all-zero `vec_i` gives `pos_o` = 0, and a non-zero `vec_i` never gives 0.
- R3: Bit 0 alone gives 1. The top bit alone gives `WIDTH`, which is binary 10000 for the default width of 16.
- R4: `pos_o` is `$clog2(WIDTH+1)` bits wide and never exceeds `WIDTH`. All bits set gives `WIDTH`.
- R5: Style `ONEHOT` gives the same result as R1 for every one-hot or all-zero input. Inputs with two or more bits set are outside its contract.
- R6: On every input legal for all styles, the four styles give identical results.
- R7: With a width that is not a multiple of `GROUP_W` (for example `WIDTH` = 5), styles `PRIORITY` and `SCAN_UP` still meet R1 over every input value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vec_i | input | WIDTH | Vector to search |
| pos_o | output | $clog2(WIDTH+1) | Highest set bit index plus one, 0 when empty |

## Verification
The block holds no state, so a wrong internal selection appears on `pos_o` in the same cycle as the input that triggers it. A fault in the group pick of the grouped encoder only shows when the top two populated groups differ, and a fault in the in-group pick only shows for particular bit patterns inside a group. For that reason the bench sweeps every 16-bit value and every 5-bit value, rather than relying on one-hot patterns alone. A wrong loop direction or hit-retention fault shows only on inputs with several bits set, and the exhaustive sweep covers those inputs too.

// File: rtl/lead_one_pkg.sv
package lead_one_pkg;
  function automatic int unsigned pos_bits(int unsigned w);
    return $clog2(w + 1);
  endfunction
endpackage

// File: rtl/lead_one_onehot.sv
module lead_one_onehot
  import lead_one_pkg::*;
#(
  parameter int unsigned WIDTH = 16,
  localparam int unsigned OUT_W = pos_bits(WIDTH)
) (
  input  logic [WIDTH-1:0] vec_i,
  output logic [OUT_W-1:0] pos_o
);
  always_comb begin
    pos_o = '0;
    for (int i = $low(vec_i); i <= $high(vec_i); i++) begin
      pos_o = pos_o | (vec_i[i] ? OUT_W'(i + 1) : '0);
    end
    // contract of this style: result undefined with more than one bit set
    assert_onehot_input_R5: assert ($onehot0(vec_i));
  end
endmodule

// File: rtl/lead_one_group.sv
module lead_one_group
  import lead_one_pkg::*;
#(
  parameter int unsigned WIDTH   = 16,
  parameter int unsigned GROUP_W = 4,
  localparam int unsigned OUT_W  = pos_bits(WIDTH),
  localparam int unsigned NGRP   = (WIDTH + GROUP_W - 1) / GROUP_W,
  localparam int unsigned PAD_W  = NGRP * GROUP_W,
  localparam int unsigned GSEL_W = (NGRP > 1) ? $clog2(NGRP) : 1,
  localparam int unsigned BSEL_W = (GROUP_W > 1) ? $clog2(GROUP_W) : 1
) (
  input  logic [WIDTH-1:0] vec_i,
  output logic [OUT_W-1:0] pos_o
);
  logic [PAD_W-1:0]   padded;
  logic [NGRP-1:0]    grp_any;
  logic [GSEL_W-1:0]  grp_sel;
  logic               grp_hit;
  logic [GROUP_W-1:0] grp_bits;
  logic [BSEL_W-1:0]  bit_sel;

  generate
    if (PAD_W > WIDTH) begin : g_pad
      assign padded = {{(PAD_W - WIDTH){1'b0}}, vec_i};
    end else begin : g_nopad
      assign padded = vec_i;
    end
    for (genvar g = 0; g < NGRP; g++) begin : g_any
      assign grp_any[g] = |padded[g*GROUP_W +: GROUP_W];
    end
  endgenerate

  // level 1: highest populated group
  always_comb begin
    grp_sel = '0;
    grp_hit = 1'b0;
    for (int g = 0; g < NGRP; g++) begin
      if (grp_any[g]) begin
        grp_sel = GSEL_W'(g);
        grp_hit = 1'b1;
      end
    end
  end

  assign grp_bits = padded[int'(grp_sel)*GROUP_W +: GROUP_W];

  // level 2: highest bit inside the chosen group
  always_comb begin
    bit_sel = '0;
    for (int b = 0; b < GROUP_W; b++) begin
      if (grp_bits[b]) bit_sel = BSEL_W'(b);
    end
  end

  always_comb begin
    case (grp_hit)
      1'b1:    pos_o = OUT_W'(int'(grp_sel) * GROUP_W + int'(bit_sel) + 1);
      default: pos_o = '0;
    endcase
    assert_group_nonempty_R1: assert (!grp_hit || grp_bits != '0);
  end
endmodule

// File: rtl/lead_one_scan.sv
module lead_one_scan
  import lead_one_pkg::*;
#(
  parameter int unsigned WIDTH = 16,
  parameter bit          FROM_TOP = 1'b1,
  localparam int unsigned OUT_W = pos_bits(WIDTH)
) (
  input  logic [WIDTH-1:0] vec_i,
  output logic [OUT_W-1:0] pos_o
);
  logic found;

  generate
    if (FROM_TOP) begin : g_down
      always_comb begin
        pos_o = '0;
        found = 1'b0;
        for (int i = $high(vec_i); i >= $low(vec_i); i--) begin
          if (!found && vec_i[i]) begin
            pos_o = OUT_W'(i + 1);
            found = 1'b1;
          end
        end
        assert_found_matches_R2: assert (found == (vec_i != '0));
      end
    end else begin : g_up
      always_comb begin
        pos_o = '0;
        found = 1'b0;
        for (int i = $low(vec_i); i <= $high(vec_i); i++) begin
          if (vec_i[i]) begin
            pos_o = OUT_W'(i + 1);
            found = 1'b1;
          end
        end
        assert_found_matches_R2: assert (found == (vec_i != '0));
      end
    end
  endgenerate
endmodule

// File: rtl/lead_one_det.sv
module lead_one_det
  import lead_one_pkg::*;
#(
  parameter int unsigned WIDTH   = 16,
  parameter int unsigned GROUP_W = 4,
  parameter string       STYLE   = "PRIORITY",
  localparam int unsigned OUT_W  = pos_bits(WIDTH)
) (
  input  logic [WIDTH-1:0] vec_i,
  output logic [OUT_W-1:0] pos_o
);
  localparam bit IS_ONEHOT = (STYLE == "ONEHOT");

  generate
    if (STYLE == "ONEHOT") begin : g_onehot
      lead_one_onehot #(.WIDTH(WIDTH)) u_core (.vec_i(vec_i), .pos_o(pos_o));
    end else if (STYLE == "PRIORITY") begin : g_prio
      lead_one_group #(.WIDTH(WIDTH), .GROUP_W(GROUP_W)) u_core (.vec_i(vec_i), .pos_o(pos_o));
    end else if (STYLE == "SCAN_DOWN") begin : g_sdown
      lead_one_scan #(.WIDTH(WIDTH), .FROM_TOP(1'b1)) u_core (.vec_i(vec_i), .pos_o(pos_o));
    end else if (STYLE == "SCAN_UP") begin : g_sup
      lead_one_scan #(.WIDTH(WIDTH), .FROM_TOP(1'b0)) u_core (.vec_i(vec_i), .pos_o(pos_o));
    end else begin : g_bad
      $error("lead_one_det: unknown STYLE");
    end
  endgenerate

  always_comb begin
    assert_zero_iff_empty_R2: assert ((vec_i == '0) == (pos_o == '0));
    assert_pos_in_range_R4: assert (int'(pos_o) <= WIDTH);
    for (int i = 0; i < WIDTH; i++) begin
      if (int'(pos_o) == i + 1 && (!IS_ONEHOT || $onehot0(vec_i)))
        assert_reported_bit_set_R1: assert (vec_i[i]);
      if (i >= int'(pos_o) && !IS_ONEHOT)
        assert_upper_bits_clear_R1: assert (!vec_i[i]);
    end
  end
endmodule

// File: tb/lead_one_det_test.sv
module lead_one_det_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [15:0] vec16, vec_oh;
  logic [4:0]  vec5;
  logic [4:0]  p_prio, p_oh, p_down, p_up;
  logic [2:0]  p5_prio, p5_up;

  int checks = 0;
  int errors = 0;

  lead_one_det #(.WIDTH(16), .STYLE("PRIORITY"))  uut        (.vec_i(vec16),  .pos_o(p_prio));
  lead_one_det #(.WIDTH(16), .STYLE("ONEHOT"))    uut_onehot (.vec_i(vec_oh), .pos_o(p_oh));
  lead_one_det #(.WIDTH(16), .STYLE("SCAN_DOWN")) uut_down   (.vec_i(vec16),  .pos_o(p_down));
  lead_one_det #(.WIDTH(16), .STYLE("SCAN_UP"))   uut_up     (.vec_i(vec16),  .pos_o(p_up));
  lead_one_det #(.WIDTH(5),  .STYLE("PRIORITY"))  uut_n5p    (.vec_i(vec5),   .pos_o(p5_prio));
  lead_one_det #(.WIDTH(5),  .STYLE("SCAN_UP"))   uut_n5u    (.vec_i(vec5),   .pos_o(p5_up));

  function automatic int ref_pos(int unsigned v);
    int p = 0;
    while (v != 0) begin
      v = v >> 1;
      p++;
    end
    return p;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic drive(logic [15:0] v16, logic [15:0] voh, logic [4:0] v5);
    @(negedge clk);
    vec16  = v16;
    vec_oh = voh;
    vec5   = v5;
    #(CLK_PERIOD/4);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    vec16 = '0; vec_oh = '0; vec5 = '0;
    repeat (2) @(posedge clk);

    // R2: empty vector everywhere
    drive(16'h0, 16'h0, 5'h0);
    check("R2", "prio zero",   p_prio, 0);
    check("R2", "onehot zero", p_oh,   0);
    check("R2", "down zero",   p_down, 0);
    check("R2", "up zero",     p_up,   0);
    check("R2", "n5 zero",     p5_prio, 0);

    // R3: edge bits
    drive(16'h0001, 16'h0001, 5'h01);
    check("R3", "prio bit0",   p_prio, 1);
    check("R3", "onehot bit0", p_oh,   1);
    check("R3", "n5 bit0",     p5_prio, 1);
    drive(16'h8000, 16'h8000, 5'h10);
    check("R3", "prio top",    p_prio, 5'b10000);
    check("R3", "onehot top",  p_oh,   16);
    check("R3", "down top",    p_down, 16);
    check("R3", "up top",      p_up,   16);
    check("R3", "n5 top",      p5_prio, 5);

    // R4: all ones saturates at WIDTH
    drive(16'hFFFF, 16'h0, 5'h1F);
    check("R4", "prio all ones", p_prio, 16);
    check("R4", "up all ones",   p_up,   16);
    check("R4", "n5 all ones",   p5_up,  5);

    // R5 / R6: one-hot sweep, all four styles agree
    for (int i = 0; i < 16; i++) begin
      drive(16'(1) << i, 16'(1) << i, 5'h0);
      check("R5", "onehot sweep", p_oh, i + 1);
      check("R6", "prio vs onehot", p_prio, p_oh);
      check("R6", "down vs onehot", p_down, p_oh);
      check("R6", "up vs onehot",   p_up,   p_oh);
    end

    // R1: exhaustive over 16 bits
    for (int v = 0; v < 65536; v++) begin
      drive(16'(v), 16'h0, 5'h0);
      check("R1", "prio", p_prio, ref_pos(v));
      check("R1", "down", p_down, ref_pos(v));
      check("R1", "up",   p_up,   ref_pos(v));
    end

    // R7: width 5, not a multiple of the group size
    for (int v = 0; v < 32; v++) begin
      drive(16'h0, 16'h0, 5'(v));
      check("R7", "n5 prio", p5_prio, ref_pos(v));
      check("R7", "n5 up",   p5_up,   ref_pos(v));
    end

    finish_run();
  end
endmodule